// File: doc/BRIEF.md
# Real-Time Clock Divider with Digital Rate Trim

This block turns a 32,768 Hz oscillator clock into a one-pulse-per-second tick and a one-pulse-per-minute tick. It uses a two-stage divider: a low stage that emits a tap every 256 oscillator cycles, and a high stage that counts 128 taps to one second. The oscillator's rate error is trimmed digitally at that 256-cycle tap. In a second chosen by a 64-minute schedule, the high stage either takes one extra count, so the second ends early, or the tap is held back, so the second ends late.

A five-bit magnitude N and a direction bit choose how much trim is applied and in which direction. The schedule adjusts the first second of each of the first 2×N minutes of the 64-minute cycle, and never more than 62 minutes. The block also has a factory test mode. In that mode the output that normally carries the low bit of the seconds count carries a free-running 512 Hz square wave instead, so the oscillator can be measured with a frequency counter. The seconds count here is the block's internal seconds-in-minute count.

Top module: `rtc_cal_divider`

## Requirements
- R1: With magnitude 0, every second lasts exactly 2^(PRE_W+HI_W) oscillator cycles (32,768 by default). `sec_tick` is a single-cycle pulse at the end of each second.
- R2: `min_tick` is a single-cycle pulse. It is high exactly in the cycle where `sec_tick` marks the end of the last second of a minute (second index SPM-1, with SPM = 60 by default), and at no other time.
- R3: With `cal_pos` = 1 (speed up), an adjusted second is 2^PRE_W oscillator cycles (256) shorter than nominal.
- R4: With `cal_pos` = 0 (slow down), an adjusted second is 2^(PRE_W-1) oscillator cycles (128) longer than nominal.
- R5: Only second 0 of a minute can be adjusted. That second is adjusted when the minute's index m within the MPC-minute cycle (64 by default) satisfies m < 2×N. The minute index advances on every minute boundary and wraps from MPC-1 to 0.
- R6: The number of adjusted minutes per cycle is limited to MPC-2 (62 by default). For example, with MPC = 8 and N = 31, minutes 0 to 5 are adjusted.
- R7: The magnitude and direction are latched at each second boundary, and at reset. A change to them affects only seconds that begin after the next boundary.
- R8: With `ft_en` = 1, `ft_out` is a square wave that changes level every 2^(PRE_W-3) oscillator cycles (32). That gives 512 Hz at a 32,768 Hz oscillator, whatever the trim setting.
- R9: With `ft_en` = 0, `ft_out` equals bit 0 of the seconds-in-minute count, with one cycle of delay.
- R10: `rst` is synchronous and active high. It clears the divider stages, the seconds and minute-of-cycle counts and all three outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_mag | input | CAL_W | Trim magnitude N, 0..31 |
| cal_pos | input | 1 | Trim direction: 1 shortens (speeds up), 0 lengthens (slows down) |
| ft_en | input | 1 | Frequency-test enable |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |
| min_tick | output | 1 | One-cycle pulse at each minute boundary |
| ft_out | output | 1 | Seconds-count bit 0, or the 512 Hz test wave |

## Verification
Two events can fall in the same cycle. The first pair is the minute boundary and the second boundary. The bench provokes it by shrinking a minute to two seconds, and it requires `min_tick` on every second tick of odd index and never on its own. The second pair is a trim change and a second boundary. The bench writes a new magnitude on the falling edge right after a `sec_tick`, when the latch for the new second has already closed. It then requires the schedule-adjusted second that follows to remain nominal, and the adjustment to appear one minute later.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  // Kind of adjustment applied to the second now in progress
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_ADD   = 2'd1,
    ADJ_BLANK = 2'd2
  } adj_e;
endpackage

// File: rtl/rtc_prescaler.sv
// Low divider stage: a tap every 2^PRE_W cycles, or every 1.5 * 2^PRE_W cycles when stretched
module rtc_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic stretch,
  output logic tap
);
  localparam int CW = PRE_W + 1;
  localparam logic [CW-1:0] LIM_NORM = CW'((1 << PRE_W) - 1);
  localparam logic [CW-1:0] LIM_LONG = CW'((1 << PRE_W) + (1 << (PRE_W - 1)) - 1);

  logic [CW-1:0] cnt;

  assign tap = (cnt == (stretch ? LIM_LONG : LIM_NORM));

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (tap) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_sec_stage.sv
// High divider stage: counts taps to one second; a doubled step drops one tap
module rtc_sec_stage #(
  parameter int HI_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic tap,
  input  logic dbl,
  output logic first,
  output logic sec_end
);
  logic [HI_W-1:0] hi;
  logic [HI_W:0]   nxt;

  assign nxt     = {1'b0, hi} + (dbl ? (HI_W+1)'(2) : (HI_W+1)'(1));
  assign first   = (hi == '0);
  assign sec_end = tap && nxt[HI_W];

  always_ff @(posedge clk) begin
    if (rst)          hi <= '0;
    else if (sec_end) hi <= '0;
    else if (tap)     hi <= nxt[HI_W-1:0];
  end
endmodule

// File: rtl/rtc_cal_sched.sv
// Seconds and minute-of-cycle counts, trim latch and the adjustment decision
module rtc_cal_sched
  import rtc_cal_pkg::*;
#(
  parameter int CAL_W = 5,
  parameter int SPM   = 60,
  parameter int MPC   = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 sec_end,
  input  logic [CAL_W-1:0]                     cal_mag,
  input  logic                                 cal_pos,
  output adj_e                                 adj,
  output logic [((SPM > 1) ? $clog2(SPM) : 1)-1:0] sec_idx,
  output logic                                 min_last,
  output logic [CAL_W-1:0]                     mag_q,
  output logic                                 pos_q
);
  localparam int SEC_W = (SPM > 1) ? $clog2(SPM) : 1;
  localparam int MIN_W = $clog2(MPC);
  localparam logic [31:0] MAX_ADJ = 32'(MPC - 2);

  logic [MIN_W-1:0] min_idx;
  logic [CAL_W:0]   two_n;
  logic             elig;

  assign two_n    = {mag_q, 1'b0};
  assign min_last = (sec_idx == SEC_W'(SPM - 1));
  assign elig     = (sec_idx == '0) && (32'(min_idx) < 32'(two_n)) && (32'(min_idx) < MAX_ADJ);
  assign adj      = !elig ? ADJ_NONE : (pos_q ? ADJ_ADD : ADJ_BLANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_idx <= '0;
      min_idx <= '0;
      mag_q   <= cal_mag;
      pos_q   <= cal_pos;
    end else if (sec_end) begin
      mag_q <= cal_mag;
      pos_q <= cal_pos;
      if (min_last) begin
        sec_idx <= '0;
        min_idx <= (min_idx == MIN_W'(MPC - 1)) ? '0 : min_idx + 1'b1;
      end else begin
        sec_idx <= sec_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_ft_gen.sv
// Free-running test-wave divider, untouched by trim
module rtc_ft_gen #(
  parameter int FT_W = 6
) (
  input  logic clk,
  input  logic rst,
  output logic sq
);
  logic [FT_W-1:0] cnt;

  assign sq = cnt[FT_W-1];

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider
  import rtc_cal_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int HI_W  = 7,
  parameter int CAL_W = 5,
  parameter int SPM   = 60,
  parameter int MPC   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CAL_W-1:0] cal_mag,
  input  logic             cal_pos,
  input  logic             ft_en,
  output logic             sec_tick,
  output logic             min_tick,
  output logic             ft_out
);
  localparam int FT_W  = PRE_W - 2;
  localparam int SEC_W = (SPM > 1) ? $clog2(SPM) : 1;

  logic             tap, first, sec_end, stretch, dbl, sq, min_last, pos_q;
  logic [CAL_W-1:0] mag_q;
  logic [SEC_W-1:0] sec_idx;
  adj_e             adj;

  assign stretch = (adj == ADJ_BLANK) && first;
  assign dbl     = (adj == ADJ_ADD) && first;

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .stretch(stretch), .tap(tap)
  );

  rtc_sec_stage #(.HI_W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .tap(tap), .dbl(dbl), .first(first), .sec_end(sec_end)
  );

  rtc_cal_sched #(.CAL_W(CAL_W), .SPM(SPM), .MPC(MPC)) u_sched (
    .clk(clk), .rst(rst), .sec_end(sec_end), .cal_mag(cal_mag), .cal_pos(cal_pos),
    .adj(adj), .sec_idx(sec_idx), .min_last(min_last), .mag_q(mag_q), .pos_q(pos_q)
  );

  rtc_ft_gen #(.FT_W(FT_W)) u_ft (
    .clk(clk), .rst(rst), .sq(sq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_tick <= 1'b0;
      min_tick <= 1'b0;
      ft_out   <= 1'b0;
    end else begin
      sec_tick <= sec_end;
      min_tick <= sec_end && min_last;
      ft_out   <= ft_en ? sq : sec_idx[0];
    end
  end
endmodule

// File: rtl/rtc_cal_divider_chk.sv
module rtc_cal_divider_chk #(
  parameter int CAL_W = 5,
  parameter int SPM   = 60
) (
  input logic                                     clk,
  input logic                                     rst,
  input logic                                     sec_tick,
  input logic                                     min_tick,
  input logic                                     ft_out,
  input logic                                     sec_end,
  input logic [((SPM > 1) ? $clog2(SPM) : 1)-1:0] sec_idx,
  input logic [CAL_W-1:0]                         mag_q,
  input logic                                     pos_q
);
  localparam int SEC_W = (SPM > 1) ? $clog2(SPM) : 1;

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R10: outputs are low in the cycle after a reset edge
  always @(posedge clk) begin
    if (rst_d) begin
      a_r10_reset_quiet: assert (!sec_tick && !min_tick && !ft_out)
        else $error("R10 outputs not cleared by reset");
    end
  end

  a_r1_tick_pulse: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);

  a_r2_min_needs_sec: assert property (@(posedge clk) disable iff (rst)
    min_tick |-> sec_tick);

  a_r2_min_on_last: assert property (@(posedge clk) disable iff (rst)
    (sec_end && sec_idx == SEC_W'(SPM - 1)) |=> min_tick);

  a_r7_trim_held: assert property (@(posedge clk) disable iff (rst)
    !sec_end |=> ($stable(mag_q) && $stable(pos_q)));
endmodule

bind rtc_cal_divider rtc_cal_divider_chk #(.CAL_W(CAL_W), .SPM(SPM)) u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .min_tick(min_tick), .ft_out(ft_out),
  .sec_end(sec_end), .sec_idx(sec_idx), .mag_q(mag_q), .pos_q(pos_q)
);

// File: tb/rtc_cal_divider_bench.sv
module rtc_cal_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_W = 8;
  localparam int HI_W  = 2;
  localparam int CAL_W = 5;
  localparam int SPM   = 2;
  localparam int MPC   = 8;
  localparam int NOM   = 1 << (PRE_W + HI_W);
  localparam int SHORT = NOM - (1 << PRE_W);
  localparam int LONG  = NOM + (1 << (PRE_W - 1));
  localparam int FT_HALF = 1 << (PRE_W - 3);
  localparam int WD_CYCLES = 190000;

  // stimulus / expected table: magnitude, direction, adjusted seconds per cycle
  localparam int NVEC = 6;
  localparam int VMAG[NVEC] = '{0, 1, 1, 3, 31, 31};
  localparam int VPOS[NVEC] = '{1, 1, 0, 1, 1, 0};
  localparam int VADJ[NVEC] = '{0, 2, 2, 6, 6, 6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CAL_W-1:0] cal_mag = '0;
  logic cal_pos = 1'b0;
  logic ft_en = 1'b0;
  logic sec_tick, min_tick, ft_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_cal_divider #(.PRE_W(PRE_W), .HI_W(HI_W), .CAL_W(CAL_W), .SPM(SPM), .MPC(MPC)) u_rtc_cal_divider (
    .clk(clk), .rst(rst), .cal_mag(cal_mag), .cal_pos(cal_pos), .ft_en(ft_en),
    .sec_tick(sec_tick), .min_tick(min_tick), .ft_out(ft_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input int k, input int mag, input int pos);
    int s = k % SPM;
    int m = (k / SPM) % MPC;
    int lim = (2 * mag < MPC - 2) ? 2 * mag : MPC - 2;
    if (s == 0 && m < lim) return pos ? SHORT : LONG;
    return NOM;
  endfunction

  task automatic do_reset(input int mag, input int pos, input bit ft);
    @(negedge clk);
    rst = 1'b1; cal_mag = CAL_W'(mag); cal_pos = pos[0]; ft_en = ft;
    repeat (3) @(negedge clk);
    check(!sec_tick && !min_tick && !ft_out, "R10 reset outputs", {29'd0, sec_tick, min_tick, ft_out}, 0);
    rst = 1'b0;
  endtask

  // Walk seconds, checking lengths (R1 R3 R4 R5 R6), minute ticks (R2), parity (R9)
  task automatic run_row(input int mag, input int pos, input int exp_adj);
    int t = 0, prev = 0, k = 0, adj_cnt = 0;
    do_reset(mag, pos, 1'b0);
    while (k < 2 * MPC + 2) begin
      @(negedge clk);
      t++;
      if (sec_tick) begin
        if (k >= 1) begin
          check((t - prev) == exp_len(k, mag, pos), "R1/R3/R4/R5 second length", t - prev, exp_len(k, mag, pos));
          if (k <= SPM * MPC && (t - prev) != NOM) adj_cnt++;
        end
        check(min_tick == ((k % SPM) == SPM - 1), "R2 minute tick", int'(min_tick), int'((k % SPM) == SPM - 1));
        prev = t;
        k++;
      end else begin
        if (min_tick) check(1'b0, "R2 minute tick alone", 1, 0);
        if (k >= 1 && (t - prev) == 100)
          check(ft_out == ((k % SPM) & 1), "R9 seconds lsb", int'(ft_out), (k % SPM) & 1);
      end
    end
    check(adj_cnt == exp_adj, "R5/R6 adjusted seconds per cycle", adj_cnt, exp_adj);
  endtask

  initial begin
    // table walk
    for (int i = 0; i < NVEC; i++) run_row(VMAG[i], VPOS[i], VADJ[i]);

    // R7: trim written just after a boundary reaches only the second after next
    begin
      int t = 0, prev = 0, k = 0;
      do_reset(0, 1, 1'b0);
      while (k < 6) begin
        @(negedge clk);
        t++;
        if (sec_tick) begin
          if (k == 1) begin cal_mag = CAL_W'(3); cal_pos = 1'b1; end
          if (k == 2) check((t - prev) == NOM, "R7 latched second unchanged", t - prev, NOM);
          if (k == 3) check((t - prev) == NOM, "R7 mid-minute second", t - prev, NOM);
          if (k == 4) check((t - prev) == SHORT, "R7 new trim applied", t - prev, SHORT);
          prev = t;
          k++;
        end
      end
    end

    // R8: test wave spacing under heavy slow-down trim, across a stretched second
    begin
      int since = 0, edges = 0;
      logic last;
      do_reset(31, 0, 1'b1);
      @(negedge clk);
      last = ft_out;
      while (edges < 41) begin
        @(negedge clk);
        since++;
        if (ft_out != last) begin
          if (edges >= 1) check(since == FT_HALF, "R8 test wave half period", since, FT_HALF);
          edges++;
          since = 0;
          last = ft_out;
        end
      end
    end

    // R10: reset mid-run clears the outputs and restarts the second
    begin
      int t = 0;
      do_reset(0, 1, 1'b0);
      repeat (500) @(negedge clk);
      do_reset(0, 1, 1'b0);
      while (!sec_tick) begin @(negedge clk); t++; end
      check(t == NOM, "R10 first second after reset", t, NOM);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=finished", WD_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule